// File: doc/BRIEF.md
# Timestamped Capture Channel Buffer

This block serves as one capture lane of a multi-lane converter front end. On each cycle where the sample strobe is high and the lane is enabled, it takes a 14-bit converted value and combines it with the current value of an 18-bit free-running timestamp counter. The result is one 32-bit word, which is written into a four-entry first-in first-out buffer. A bus reader pops words through a read strobe. The popped word appears on the read-data port one cycle after the strobe and stays there until the next read. The current fill count is always visible.

Four event flags track the buffer: full, empty, underflow and overflow. Each flag has an enable mask bit and a sticky status bit. Software clears a status bit by writing a one to it. The clear takes effect one cycle after the write. If the event is detected again in that cycle, the event wins and the bit stays set. A lane mode input selects the output path. In interrupt mode, the masked status drives the interrupt line. In DMA mode, the interrupt line is held low and a DMA request is raised whenever the buffer holds data. A synchronous soft reset clears the buffer and the status flags.

Top module: `stcap_channel`

## Requirements
- R1: Each stored word carries the sample in bits [13:0] and the timestamp in bits [31:14]. The timestamp is the counter value present in the cycle the strobe is accepted.
- R2: The buffer holds at most 4 words, returns them in arrival order, and reports its occupancy 0..4 on the 3-bit fill output.
- R3: Status and mask bits share one encoding: bit 0 full, bit 1 empty, bit 2 underflow, bit 3 overflow. Full and empty set while the buffer is in that state.
- R4: When the clear strobe is high, a 1 in the clear mask clears the matching status bit at the second clock edge, not the first. A 0 in the clear mask leaves the bit unchanged.
- R5: If a status bit's event is detected at the same edge where its clear would take effect, the bit stays set.
- R6: A sample accepted while the buffer is full and no read is made sets overflow. The sample is dropped, the fill count is unchanged, and the stored words stay intact.
- R7: A read while the buffer is empty sets underflow, returns zero on the read-data port, and leaves the fill count at zero.
- R8: A simultaneous read and accepted sample on a full buffer both proceed, with the fill count unchanged and no overflow. On an empty buffer, the read underflows and returns zero while the sample is stored, giving a fill count of 1.
- R9: The interrupt is the OR of status AND mask and is held low in DMA mode. The DMA request is high only in DMA mode with a non-empty buffer.
- R10: While soft reset is high, the fill count, status, pending clears and read data return to zero. Empty status sets again one edge after soft reset is released.
- R11: The timestamp counter advances by one per clock only while the lane is enabled. It wraps at 2^18. Sample strobes are ignored while the lane is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_en | input | 1 | Lane enable: counter runs, samples accepted |
| soft_rst | input | 1 | Synchronous clear of buffer and flags |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | 14 | Converted sample |
| rd_stb | input | 1 | Pop one word |
| rd_word | output | 32 | Last popped word (zero on underflow) |
| fill_lvl | output | 3 | Number of stored words |
| evt_mask | input | 4 | Interrupt enable per event |
| clr_stb | input | 1 | Status clear write strobe |
| clr_mask | input | 4 | Ones select status bits to clear |
| evt_stat | output | 4 | Sticky event status |
| dma_sel | input | 1 | 1 selects DMA mode, 0 interrupt mode |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench goes after the one-cycle delay of a clear and the rule that an event wins over a clear in the same cycle. A design that cleared at once, or that let the clear win, would show the status bit low one cycle too early or lose an overflow that arrived during the clear. It also drives a read and a sample together on a full buffer and on an empty one. A wrong design would either report a false overflow, change the fill count, or lose or duplicate a word. A scoreboard queue predicts every popped word, including its timestamp while the lane is paused. Any packing error, ordering error or corruption of stored words on overflow therefore shows up as a mismatched word.

// File: rtl/stcap_pkg.sv
package stcap_pkg;
   localparam int NUM_EV = 4;
   typedef enum int unsigned {
      EV_FULL  = 0,
      EV_EMPTY = 1,
      EV_UNDER = 2,
      EV_OVER  = 3
   } ev_idx_e;
endpackage

// File: rtl/stcap_stamp.sv
module stcap_stamp #(
   parameter int TS_W = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   output logic [TS_W-1:0] stamp
);
   if (TS_W < 2) begin : g_bad_ts
      $error("stcap_stamp: TS_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stamp <= '0;
      else if (run) stamp <= stamp + 1'b1;
   end
endmodule

// File: rtl/stcap_fifo.sv
module stcap_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic              pop,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty,
   output logic              ovf_evt,
   output logic              udf_evt
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("stcap_fifo: DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || pop);
   assign ovf_evt = push && full && !pop;
   assign udf_evt = pop && empty;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         rdata  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         rdata  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_next(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
         if (pop)     rdata  <= do_pop ? mem[rd_ptr] : '0;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));
   // R6
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
      ovf_evt |=> $stable(level));
   // R7
   udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
      udf_evt |=> (rdata == '0));
endmodule

// File: rtl/stcap_events.sv
module stcap_events #(
   parameter int NEV = stcap_pkg::NUM_EV
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic [NEV-1:0] set_vec,
   input  logic           clr_stb,
   input  logic [NEV-1:0] clr_mask,
   output logic [NEV-1:0] status
);
   logic [NEV-1:0] pend;

   for (genvar i = 0; i < NEV; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i]   <= 1'b0;
            status[i] <= 1'b0;
         end else if (flush) begin
            pend[i]   <= 1'b0;
            status[i] <= 1'b0;
         end else begin
            pend[i]   <= clr_stb && clr_mask[i];
            status[i] <= set_vec[i] || (status[i] && !pend[i]);
         end
      end

      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
         set_vec[i] |=> status[i]);
      // R4
      clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
         (pend[i] && !set_vec[i]) |=> !status[i]);
   end
endmodule

// File: rtl/stcap_channel.sv
module stcap_channel #(
   parameter int SMP_W = 14,
   parameter int TS_W  = 18,
   parameter int DEPTH = 4,
   localparam int WORD_W = SMP_W + TS_W,
   localparam int LVL_W  = $clog2(DEPTH + 1),
   localparam int NEV    = stcap_pkg::NUM_EV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lane_en,
   input  logic              soft_rst,
   input  logic              smp_vld,
   input  logic [SMP_W-1:0]  smp_val,
   input  logic              rd_stb,
   output logic [WORD_W-1:0] rd_word,
   output logic [LVL_W-1:0]  fill_lvl,
   input  logic [NEV-1:0]    evt_mask,
   input  logic              clr_stb,
   input  logic [NEV-1:0]    clr_mask,
   output logic [NEV-1:0]    evt_stat,
   input  logic              dma_sel,
   output logic              irq,
   output logic              dma_req
);
   import stcap_pkg::*;

   if (SMP_W < 1) begin : g_bad_smp
      $error("stcap_channel: SMP_W must be positive");
   end

   logic [TS_W-1:0] stamp;
   logic            full, empty, ovf_evt, udf_evt;
   logic [NEV-1:0]  set_vec;

   stcap_stamp #(.TS_W(TS_W)) u_stamp (
      .clk(clk), .rst_n(rst_n), .run(lane_en), .stamp(stamp)
   );

   stcap_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(smp_vld && lane_en), .pop(rd_stb),
      .wdata({stamp, smp_val}), .rdata(rd_word), .level(fill_lvl),
      .full(full), .empty(empty), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[EV_FULL]  = full;
      set_vec[EV_EMPTY] = empty;
      set_vec[EV_UNDER] = udf_evt;
      set_vec[EV_OVER]  = ovf_evt;
   end

   stcap_events #(.NEV(NEV)) u_events (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst), .set_vec(set_vec),
      .clr_stb(clr_stb), .clr_mask(clr_mask), .status(evt_stat)
   );

   assign irq     = !dma_sel && |(evt_stat & evt_mask);
   assign dma_req = dma_sel && !empty;

   // R10
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (fill_lvl == '0 && evt_stat == '0 && rd_word == '0));
endmodule

// File: tb/test_stcap_channel.sv
module test_stcap_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lane_en = 1'b1, soft_rst = 1'b0, smp_vld = 1'b0, rd_stb = 1'b0;
   logic [13:0] smp_val = '0;
   logic [31:0] rd_word;
   logic [2:0]  fill_lvl;
   logic [3:0]  evt_mask = '0, clr_mask = '0, evt_stat;
   logic        clr_stb = 1'b0, dma_sel = 1'b0, irq, dma_req;

   int errors = 0, checks = 0;
   logic [17:0] ts_model;
   logic [31:0] sb[$];

   always #4 clk = ~clk;

   stcap_channel i_stcap_channel (
      .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .soft_rst(soft_rst),
      .smp_vld(smp_vld), .smp_val(smp_val), .rd_stb(rd_stb), .rd_word(rd_word),
      .fill_lvl(fill_lvl), .evt_mask(evt_mask), .clr_stb(clr_stb),
      .clr_mask(clr_mask), .evt_stat(evt_stat), .dma_sel(dma_sel),
      .irq(irq), .dma_req(dma_req)
   );

   // R11 reference: counts enabled clocks since reset
   always @(posedge clk) begin
      if (!rst_n)       ts_model <= '0;
      else if (lane_en) ts_model <= ts_model + 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // driver: sample in, optional read in the same cycle; scoreboard predicts
   task automatic cycle(input logic push, input logic [13:0] d, input logic pop, input string req);
      logic [31:0] exp_rd;
      logic        had = (sb.size() != 0);
      exp_rd = had ? sb[0] : 32'h0;
      smp_vld = push; smp_val = d; rd_stb = pop;
      if (pop && had) void'(sb.pop_front());
      if (push && lane_en && (sb.size() < 4 || (pop && had)))
         sb.push_back({ts_model, d});
      tick();
      smp_vld = 1'b0; rd_stb = 1'b0;
      if (pop) chk(req, rd_word, exp_rd);
   endtask

   task automatic clear(input logic [3:0] m);
      clr_stb = 1'b1; clr_mask = m;
      tick();
      clr_stb = 1'b0; clr_mask = '0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk); tick(); tick();
      chk("R10 reset fill", {29'd0, fill_lvl}, 0);
      chk("R10 reset status", {28'd0, evt_stat}, 0);
      chk("R9 reset irq/dma", {30'd0, irq, dma_req}, 0);
      chk("R10 reset rd_word", rd_word, 0);
      rst_n = 1'b1;
      tick();
      chk("R3 empty flag bit1", {28'd0, evt_stat}, 4'b0010);
      // R5 clear of empty while still empty is overridden
      clear(4'b0010); tick();
      chk("R5 empty persists", {31'd0, evt_stat[1]}, 1);

      // R1 R2 packing and order
      cycle(1, 14'h1234, 0, "");
      cycle(1, 14'h3FFF, 0, "");
      cycle(1, 14'h0001, 0, "");
      chk("R2 level 3", {29'd0, fill_lvl}, 3);
      cycle(0, 0, 1, "R1 word0");
      cycle(0, 0, 1, "R1 word1");
      cycle(0, 0, 1, "R2 word2");
      chk("R2 level 0", {29'd0, fill_lvl}, 0);

      // R11 disabled lane ignores samples, counter holds
      lane_en = 1'b0;
      tick(); tick(); tick();
      cycle(1, 14'h0BAD, 0, "");
      chk("R11 ignored when disabled", {29'd0, fill_lvl}, 0);
      lane_en = 1'b1;
      cycle(1, 14'h0777, 0, "");
      cycle(0, 0, 1, "R11 stamp after pause");

      // fill and overflow
      for (int k = 0; k < 4; k++) cycle(1, 14'(16'h100 + k), 0, "");
      chk("R2 level 4", {29'd0, fill_lvl}, 4);
      tick();
      clear(4'b1111); tick();
      chk("R4 R3 only full remains", {28'd0, evt_stat}, 4'b0001);
      cycle(1, 14'h2AAA, 0, "");
      chk("R6 overflow flag", {31'd0, evt_stat[3]}, 1);
      chk("R6 level held", {29'd0, fill_lvl}, 4);

      // R9 interrupt and DMA steering
      evt_mask = 4'b1000;
      #1 chk("R9 irq masked on", {31'd0, irq}, 1);
      dma_sel = 1'b1;
      #1 chk("R9 dma mode", {30'd0, irq, dma_req}, 2'b01);
      dma_sel = 1'b0; evt_mask = 4'b0100;
      #1 chk("R9 irq masked off", {31'd0, irq}, 0);
      evt_mask = '0;

      // R4 one-cycle delayed clear, zero writes ignored
      clear(4'b1000);
      chk("R4 not yet cleared", {31'd0, evt_stat[3]}, 1);
      tick();
      chk("R4 cleared", {31'd0, evt_stat[3]}, 0);
      clear(4'b0000); tick();
      chk("R4 zero write no effect", {28'd0, evt_stat}, 4'b0001);

      // R5 overflow arriving with the clear wins
      cycle(1, 14'h2BBB, 0, "");
      clear(4'b1000);
      cycle(1, 14'h2CCC, 0, "");
      chk("R5 event beats clear", {31'd0, evt_stat[3]}, 1);
      tick();
      chk("R5 stays set", {31'd0, evt_stat[3]}, 1);
      clear(4'b1000); tick();

      // R8 push and pop together on full
      cycle(1, 14'h1111, 1, "R8 read on full");
      tick();
      chk("R8 level kept", {29'd0, fill_lvl}, 4);
      chk("R8 no overflow", {31'd0, evt_stat[3]}, 0);
      for (int k = 0; k < 4; k++) cycle(0, 0, 1, "R6 contents kept");

      // R7 underflow
      cycle(0, 0, 1, "R7 zero on empty read");
      chk("R7 underflow flag", {31'd0, evt_stat[2]}, 1);
      chk("R7 level 0", {29'd0, fill_lvl}, 0);
      dma_sel = 1'b1;
      #1 chk("R9 no dma when empty", {31'd0, dma_req}, 0);
      dma_sel = 1'b0;

      // R8 push and pop together on empty
      cycle(1, 14'h0F0F, 1, "R8 read on empty");
      chk("R8 level 1", {29'd0, fill_lvl}, 1);

      // R10 soft reset
      soft_rst = 1'b1; tick();
      chk("R10 soft level", {29'd0, fill_lvl}, 0);
      chk("R10 soft status", {28'd0, evt_stat}, 0);
      soft_rst = 1'b0; sb.delete();
      tick();
      chk("R10 empty after soft", {28'd0, evt_stat}, 4'b0010);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule